// File: doc/BRIEF.md
# Multiplexed Parallel Bus Target

This block is the responding side of a shared parallel bus on which one set of 32 lines carries first an address and then data. Four companion lanes carry a command code during the address cycle and per-byte write/read qualifiers during every later cycle. All control lines are active low and are sampled on the rising clock edge. When the bus frame signal goes low, the block latches the address and command, decides whether the access is meant for it, and then moves 32-bit words to or from a small internal register file. A word moves only on an edge where both sides signal ready.

The target claims memory reads and writes whose address falls inside a parameterised window. It claims configuration reads and writes when its configuration select input is high. It holds back the first word for a fixed number of wait cycles. After a set number of words in one burst it asks the initiator to stop. Every control output it drives low is driven high for one clock before its output enable is released, so that the next bus owner sees a clean line.

Top module: `bus_target`

## Requirements
- R1: While reset is low, devsel_n, trdy_n and stop_n are high, ctl_oe and ad_oe are low, ad_out is zero, and every internal register reads back as zero afterwards.
- R2: On the first rising edge where frame_n is low and the block is idle, ad_in is taken as the address and cbe_n as the command. Command 4'b0110 (memory read) and 4'b0111 (memory write) are claimed when ad_in[31:WIN_BITS] equals BASE_ADDR[31:WIN_BITS]. A claim drives devsel_n low and ctl_oe high from the next cycle on.
- R3: Command 4'b1010 (configuration read) and 4'b1011 (configuration write) are claimed when idsel is high on the address edge and ad_in[1:0] is 2'b00, whatever the upper address bits are. With idsel low they are not claimed.
- R4: A transaction that is not claimed (any other command code, an address outside the window, or a configuration command without idsel) leaves devsel_n high and ctl_oe low throughout and changes no register. The block waits for frame_n and irdy_n both high before it looks for a new address cycle.
- R5: trdy_n stays high for the first WAIT_STATES data cycles of a claimed transaction and then goes low. A word transfers only on an edge where irdy_n and trdy_n are both low.
- R6: On a write transfer, byte lane b (ad_in[8b+7:8b]) of the addressed register is updated only when cbe_n[b] is 0. The other lanes keep their value.
- R7: A read drives ad_oe high from the cycle after the address edge until the transaction ends. ad_out carries the full 32-bit register word selected by the current index, and it stays unchanged through every cycle in which no word transfers.
- R8: The register index starts at ad_in[REG_IDX_W+1:2] of the address cycle. It advances by one per transferred word and wraps at 2^REG_IDX_W.
- R9: The transaction ends on the transfer edge that sees frame_n high. In the next cycle devsel_n, trdy_n and stop_n are high with ctl_oe still high and ad_oe low. One cycle later ctl_oe is low.
- R10: When BURST_LIMIT words have transferred and frame_n is still low, trdy_n goes high and stop_n goes low. Both hold until an edge sees frame_n high; the R9 release then follows.
- R11: trdy_n is never low while devsel_n is high, and trdy_n and stop_n are never low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Transaction frame from the initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration select, active high |
| ad_in | input | 32 | Multiplexed address/data lines as seen on the bus |
| cbe_n | input | 4 | Command in the address cycle, active-low byte enables afterwards |
| ad_out | output | 32 | Read data driven onto the address/data lines |
| ad_oe | output | 1 | Output enable for ad_out |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop request to the initiator, active low |
| ctl_oe | output | 1 | Output enable shared by devsel_n, trdy_n and stop_n |

## Verification
The bench targets four corner cases. A burst that crosses the top of the register window must wrap back to index zero; a design that did not wrap would write past the file or land on the wrong word. A partial-byte write must merge into the existing word; a design that ignored the enables would clobber the masked bytes. A read must hold its word through both target wait cycles and an initiator pause; a design that advanced its index on trdy alone would skip a word. The release of the control lines must come one cycle after the last transfer or after the stop has been seen. A unit that dropped ctl_oe at once would break the handoff, and one that was blind to the address window or idsel would answer foreign accesses and corrupt its registers.

// File: rtl/bt_pkg.sv
package bt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_HALT,
        ST_RELEASE,
        ST_IGNORE
    } tgt_state_e;

    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;
    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    localparam int BUS_W   = 32;
    localparam int LANES   = 4;

endpackage

// File: rtl/bt_decode.sv
module bt_decode
    import bt_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h8000_0000,
    parameter int          WIN_BITS  = 12
) (
    input  logic [BUS_W-1:0] addr,
    input  logic [LANES-1:0] cmd,
    input  logic             cfg_sel,
    output logic             claim,
    output logic             claim_read
);
    localparam int TAG_W = BUS_W - WIN_BITS;

    logic [TAG_W-1:0] tag_addr;
    logic [TAG_W-1:0] tag_base;
    logic             mem_hit;
    logic             cfg_hit;

    assign tag_addr = addr[BUS_W-1:WIN_BITS];
    assign tag_base = BASE_ADDR[BUS_W-1:WIN_BITS];
    assign mem_hit  = (tag_addr == tag_base);
    assign cfg_hit  = cfg_sel && (addr[1:0] == 2'b00);

    always_comb begin
        claim      = 1'b0;
        claim_read = 1'b0;
        unique case (cmd)
            CMD_MEM_RD: begin claim = mem_hit; claim_read = 1'b1; end
            CMD_MEM_WR: begin claim = mem_hit; claim_read = 1'b0; end
            CMD_CFG_RD: begin claim = cfg_hit; claim_read = 1'b1; end
            CMD_CFG_WR: begin claim = cfg_hit; claim_read = 1'b0; end
            default:    begin claim = 1'b0;    claim_read = 1'b0; end
        endcase
    end

endmodule

// File: rtl/bt_regfile.sv
module bt_regfile
    import bt_pkg::*;
#(
    parameter int REG_IDX_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_IDX_W-1:0] idx,
    input  logic [BUS_W-1:0]     wr_data,
    input  logic [LANES-1:0]     wr_lane,
    output logic [BUS_W-1:0]     rd_data
);
    localparam int DEPTH = 1 << REG_IDX_W;

    logic [BUS_W-1:0] regs_q [DEPTH];
    logic [BUS_W-1:0] regs_d [DEPTH];
    logic [BUS_W-1:0] merged;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign merged[8*b +: 8] = wr_lane[b] ? wr_data[8*b +: 8] : regs_q[idx][8*b +: 8];
    end

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            regs_d[idx] = merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_data = regs_q[idx];

    // R6
    lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_lane[0]) |=> (regs_q[$past(idx)][7:0] == $past(rd_data[7:0])));

endmodule

// File: rtl/bt_seq.sv
module bt_seq
    import bt_pkg::*;
#(
    parameter int REG_IDX_W   = 3,
    parameter int WAIT_STATES = 2,
    parameter int BURST_LIMIT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_n,
    input  logic                 irdy_n,
    input  logic                 claim,
    input  logic                 claim_read,
    input  logic [REG_IDX_W-1:0] start_idx,
    output logic                 devsel_n,
    output logic                 trdy_n,
    output logic                 stop_n,
    output logic                 ctl_oe,
    output logic                 ad_oe,
    output logic                 xfer,
    output logic                 wr_en,
    output logic [REG_IDX_W-1:0] idx
);
    localparam int WAIT_W = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1;
    localparam int CNT_W  = $clog2(BURST_LIMIT + 1);

    typedef struct packed {
        tgt_state_e           st;
        logic                 devsel_n;
        logic                 trdy_n;
        logic                 stop_n;
        logic                 ctl_oe;
        logic                 ad_oe;
        logic                 rd;
        logic [REG_IDX_W-1:0] idx;
        logic [WAIT_W-1:0]    wait_cnt;
        logic [CNT_W-1:0]     words;
    } seq_t;

    seq_t q, d;

    assign xfer = (q.st == ST_DATA) && !irdy_n && !q.trdy_n;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (!frame_n) begin
                    if (claim) begin
                        d.st       = ST_DATA;
                        d.devsel_n = 1'b0;
                        d.ctl_oe   = 1'b1;
                        d.ad_oe    = claim_read;
                        d.rd       = claim_read;
                        d.idx      = start_idx;
                        d.wait_cnt = WAIT_W'(WAIT_STATES);
                        d.words    = '0;
                        d.trdy_n   = (WAIT_STATES != 0);
                        d.stop_n   = 1'b1;
                    end else begin
                        d.st = ST_IGNORE;
                    end
                end
            end
            ST_DATA: begin
                if (xfer) begin
                    d.idx   = q.idx + 1'b1;
                    d.words = q.words + 1'b1;
                    if (frame_n) begin
                        d.st       = ST_RELEASE;
                        d.devsel_n = 1'b1;
                        d.trdy_n   = 1'b1;
                        d.stop_n   = 1'b1;
                        d.ad_oe    = 1'b0;
                    end else if (q.words == CNT_W'(BURST_LIMIT - 1)) begin
                        d.st     = ST_HALT;
                        d.trdy_n = 1'b1;
                        d.stop_n = 1'b0;
                    end
                end else if (q.wait_cnt != '0) begin
                    d.wait_cnt = q.wait_cnt - 1'b1;
                    if (q.wait_cnt == WAIT_W'(1)) begin
                        d.trdy_n = 1'b0;
                    end
                end
            end
            ST_HALT: begin
                if (frame_n) begin
                    d.st       = ST_RELEASE;
                    d.devsel_n = 1'b1;
                    d.trdy_n   = 1'b1;
                    d.stop_n   = 1'b1;
                    d.ad_oe    = 1'b0;
                end
            end
            ST_RELEASE: begin
                d.ctl_oe = 1'b0;
                d.st     = ST_IDLE;
            end
            ST_IGNORE: begin
                if (frame_n && irdy_n) begin
                    d.st = ST_IDLE;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, devsel_n: 1'b1, trdy_n: 1'b1, stop_n: 1'b1,
                   ctl_oe: 1'b0, ad_oe: 1'b0, rd: 1'b0, idx: '0,
                   wait_cnt: '0, words: '0};
        end else begin
            q <= d;
        end
    end

    assign devsel_n = q.devsel_n;
    assign trdy_n   = q.trdy_n;
    assign stop_n   = q.stop_n;
    assign ctl_oe   = q.ctl_oe;
    assign ad_oe    = q.ad_oe;
    assign wr_en    = xfer && !q.rd;
    assign idx      = q.idx;

    // R9
    release_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.ctl_oe) |-> ($past(q.devsel_n) && $past(q.trdy_n) && $past(q.stop_n)));

    // R11
    trdy_needs_devsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.trdy_n |-> !q.devsel_n);

    // R11
    trdy_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.stop_n |-> q.trdy_n);

    // R4
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IGNORE) |-> (!q.ctl_oe && q.devsel_n && !wr_en));

    // R10
    halt_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HALT && !frame_n) |=> (q.st == ST_HALT && !q.stop_n && q.trdy_n));

endmodule

// File: rtl/bus_target.sv
module bus_target
    import bt_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR   = 32'h8000_0000,
    parameter int          WIN_BITS    = 12,
    parameter int          REG_IDX_W   = 3,
    parameter int          WAIT_STATES = 2,
    parameter int          BURST_LIMIT = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_n,
    input  logic        irdy_n,
    input  logic        idsel,
    input  logic [31:0] ad_in,
    input  logic [3:0]  cbe_n,
    output logic [31:0] ad_out,
    output logic        ad_oe,
    output logic        devsel_n,
    output logic        trdy_n,
    output logic        stop_n,
    output logic        ctl_oe
);
    logic                 claim;
    logic                 claim_read;
    logic                 xfer;
    logic                 wr_en;
    logic [REG_IDX_W-1:0] idx;
    logic [BUS_W-1:0]     rd_data;

    bt_decode #(
        .BASE_ADDR (BASE_ADDR),
        .WIN_BITS  (WIN_BITS)
    ) u_decode (
        .addr       (ad_in),
        .cmd        (cbe_n),
        .cfg_sel    (idsel),
        .claim      (claim),
        .claim_read (claim_read)
    );

    bt_seq #(
        .REG_IDX_W   (REG_IDX_W),
        .WAIT_STATES (WAIT_STATES),
        .BURST_LIMIT (BURST_LIMIT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (frame_n),
        .irdy_n     (irdy_n),
        .claim      (claim),
        .claim_read (claim_read),
        .start_idx  (ad_in[2 +: REG_IDX_W]),
        .devsel_n   (devsel_n),
        .trdy_n     (trdy_n),
        .stop_n     (stop_n),
        .ctl_oe     (ctl_oe),
        .ad_oe      (ad_oe),
        .xfer       (xfer),
        .wr_en      (wr_en),
        .idx        (idx)
    );

    bt_regfile #(
        .REG_IDX_W (REG_IDX_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .idx     (idx),
        .wr_data (ad_in),
        .wr_lane (~cbe_n),
        .rd_data (rd_data)
    );

    assign ad_out = ad_oe ? rd_data : '0;

    // R7
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && $past(ad_oe) && !$past(xfer)) |-> $stable(ad_out));

endmodule

// File: tb/tb_bus_target.sv
module tb_bus_target;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] BASE  = 32'h8000_0000;
    localparam int          WINB  = 12;
    localparam int          IDXW  = 3;
    localparam int          NREG  = 1 << IDXW;
    localparam int          WAITS = 2;
    localparam int          LIMIT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic        idsel = 1'b0;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_n = '0;
    logic [31:0] ad_out;
    logic        ad_oe, devsel_n, trdy_n, stop_n, ctl_oe;

    int checks = 0;
    int errors = 0;
    bit summary_done = 0;

    logic [31:0] wq[$];
    logic [3:0]  bq[$];
    logic [31:0] rq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_target #(
        .BASE_ADDR(BASE), .WIN_BITS(WINB), .REG_IDX_W(IDXW),
        .WAIT_STATES(WAITS), .BURST_LIMIT(LIMIT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .idsel(idsel), .ad_in(ad_in), .cbe_n(cbe_n), .ad_out(ad_out),
        .ad_oe(ad_oe), .devsel_n(devsel_n), .trdy_n(trdy_n),
        .stop_n(stop_n), .ctl_oe(ctl_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: mode 0 idle, 1 moving data, 2 stop asked, 3 letting go, 4 not ours
    int          m_mode, m_wait, m_cnt, m_idx;
    bit          m_rd;
    logic [31:0] m_mem [NREG];
    logic        e_devsel, e_trdy, e_stop, e_ctl, e_adoe;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_wait = 0; m_cnt = 0; m_idx = 0; m_rd = 0;
            e_devsel = 1; e_trdy = 1; e_stop = 1; e_ctl = 0; e_adoe = 0;
            foreach (m_mem[i]) m_mem[i] = '0;
        end else begin
            case (m_mode)
                0: if (!frame_n) begin
                    bit ours;
                    bit in_win;
                    in_win = (ad_in >> WINB) == (BASE >> WINB);
                    ours = 0;
                    m_rd = (cbe_n == 4'h6) || (cbe_n == 4'hA);
                    if (cbe_n == 4'h6 || cbe_n == 4'h7) ours = in_win;
                    if (cbe_n == 4'hA || cbe_n == 4'hB) ours = idsel && (ad_in[1:0] == 0);
                    if (ours) begin
                        m_mode = 1; m_idx = (ad_in >> 2) % NREG; m_wait = WAITS; m_cnt = 0;
                        e_devsel = 0; e_ctl = 1; e_adoe = m_rd; e_trdy = (WAITS != 0); e_stop = 1;
                    end else begin
                        m_mode = 4;
                    end
                end
                1: if (!irdy_n && !e_trdy) begin
                    if (!m_rd) begin
                        for (int b = 0; b < 4; b++)
                            if (!cbe_n[b]) m_mem[m_idx][8*b +: 8] = ad_in[8*b +: 8];
                    end
                    m_idx = (m_idx + 1) % NREG;
                    m_cnt++;
                    if (frame_n) begin
                        m_mode = 3; e_devsel = 1; e_trdy = 1; e_stop = 1; e_adoe = 0;
                    end else if (m_cnt == LIMIT) begin
                        m_mode = 2; e_trdy = 1; e_stop = 0;
                    end
                end else if (m_wait > 0) begin
                    m_wait--;
                    if (m_wait == 0) e_trdy = 0;
                end
                2: if (frame_n) begin
                    m_mode = 3; e_devsel = 1; e_trdy = 1; e_stop = 1; e_adoe = 0;
                end
                3: begin m_mode = 0; e_ctl = 0; end
                4: if (frame_n && irdy_n) m_mode = 0;
                default: m_mode = 0;
            endcase
        end
    end

    // Per-clock comparison, half a period after each rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(devsel_n === e_devsel, "R2 devsel_n", 32'(devsel_n), 32'(e_devsel));
            chk(trdy_n === e_trdy, "R5 trdy_n", 32'(trdy_n), 32'(e_trdy));
            chk(stop_n === e_stop, "R10 stop_n", 32'(stop_n), 32'(e_stop));
            chk(ctl_oe === e_ctl, "R9 ctl_oe", 32'(ctl_oe), 32'(e_ctl));
            chk(ad_oe === e_adoe, "R7 ad_oe", 32'(ad_oe), 32'(e_adoe));
            if (e_adoe)
                chk(ad_out === m_mem[m_idx], "R7 ad_out", ad_out, m_mem[m_idx]);
            chk(!(!trdy_n && (!stop_n || devsel_n)), "R11 trdy exclusivity",
                {29'd0, trdy_n, stop_n, devsel_n}, 32'h0);
        end
    end

    task automatic txn(input logic [3:0] cmd, input logic [31:0] addr, input logic sel,
                       input int n, input int gap, output bit claimed);
        int  k = 0;
        int  t = 0;
        int  gl = gap;
        bit  done = 0;
        claimed = 0;
        rq.delete();
        frame_n = 0; ad_in = addr; cbe_n = cmd; idsel = sel; irdy_n = 1;
        @(negedge clk);
        idsel = 0;
        while (!done) begin
            if (!devsel_n) claimed = 1;
            if (!stop_n) begin
                frame_n = 1; irdy_n = 0; done = 1;
            end else if (!claimed && t >= 4) begin
                frame_n = 1; irdy_n = 0; done = 1;
            end else begin
                ad_in = (k < wq.size()) ? wq[k] : 32'h0;
                cbe_n = (k < bq.size()) ? bq[k] : 4'h0;
                if (k == 1 && gl > 0) begin
                    irdy_n = 1; frame_n = 0; gl--;
                end else begin
                    irdy_n = 0; frame_n = (k == n - 1);
                end
                if (!irdy_n && !trdy_n) begin
                    rq.push_back(ad_out);
                    k++;
                    if (frame_n) done = 1;
                end
            end
            t++;
            if (t > 40) done = 1;
            @(negedge clk);
        end
        frame_n = 1; irdy_n = 1; cbe_n = '0; ad_in = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        bit c;
        logic [31:0] ea, eb, ec, ed;
        ea = 32'h1122_3344; eb = 32'h5566_7788; ec = 32'h99AA_BBCC; ed = 32'hC0FF_EE01;

        repeat (3) @(negedge clk);
        // R1: outputs under reset
        chk(devsel_n && trdy_n && stop_n, "R1 reset controls high",
            {29'd0, devsel_n, trdy_n, stop_n}, 32'h7);
        chk(!ctl_oe && !ad_oe && ad_out == 0, "R1 reset enables low",
            {ad_out[29:0], ctl_oe, ad_oe}, 32'h0);
        rst_n = 1;
        @(negedge clk);

        // R1: register cleared
        wq.delete(); bq.delete();
        txn(4'h6, BASE, 0, 1, 0, c);
        chk(c && rq.size() == 1 && rq[0] == 0, "R1 register zero after reset",
            rq.size() > 0 ? rq[0] : 32'hFFFF_FFFF, 32'h0);

        // R2 R8: three-word write burst from index 1
        wq = '{ea, eb, ec};
        txn(4'h7, BASE + 32'h4, 0, 3, 0, c);
        chk(c, "R2 memory write claimed", 32'(c), 32'h1);

        // R7 R8: read back with an initiator pause
        wq.delete();
        txn(4'h6, BASE + 32'h4, 0, 3, 2, c);
        chk(rq.size() == 3, "R8 read burst length", rq.size(), 3);
        if (rq.size() == 3) begin
            chk(rq[0] == ea, "R8 word0", rq[0], ea);
            chk(rq[1] == eb, "R8 word1", rq[1], eb);
            chk(rq[2] == ec, "R7 word2 after pause", rq[2], ec);
        end

        // R6: lanes 0 and 2 enabled (cbe_n = 4'b1010)
        wq = '{32'hAABB_CCDD}; bq = '{4'b1010};
        txn(4'h7, BASE + 32'h4, 0, 1, 0, c);
        wq.delete(); bq.delete();
        txn(4'h6, BASE + 32'h4, 0, 1, 0, c);
        chk(rq.size() == 1 && rq[0] == 32'h11BB_33DD, "R6 byte merge",
            rq.size() > 0 ? rq[0] : 32'hFFFF_FFFF, 32'h11BB_33DD);

        // R3: configuration access through idsel
        wq = '{ed};
        txn(4'hB, 32'h0000_0018, 1, 1, 0, c);
        chk(c, "R3 config write claimed", 32'(c), 32'h1);
        wq.delete();
        txn(4'hA, 32'h0000_0018, 1, 1, 0, c);
        chk(rq.size() == 1 && rq[0] == ed, "R3 config read data",
            rq.size() > 0 ? rq[0] : 32'hFFFF_FFFF, ed);
        txn(4'hA, 32'h0000_0018, 0, 1, 0, c);
        chk(!c, "R3 config read without idsel not claimed", 32'(c), 32'h0);

        // R4: foreign window and foreign command
        wq = '{32'hDEAD_0000};
        txn(4'h7, 32'h4000_0010, 0, 1, 0, c);
        chk(!c, "R4 outside window ignored", 32'(c), 32'h0);
        txn(4'h3, BASE + 32'h10, 0, 1, 0, c);
        chk(!c, "R4 other command ignored", 32'(c), 32'h0);
        wq.delete();
        txn(4'h6, BASE + 32'h10, 0, 1, 0, c);
        chk(rq.size() == 1 && rq[0] == 0, "R4 register untouched",
            rq.size() > 0 ? rq[0] : 32'hFFFF_FFFF, 32'h0);

        // R10 R8: six-word write from index 6 stops after four, wrapping to 0
        wq = '{32'hE000_0000, 32'hE111_1111, 32'hE222_2222,
               32'hE333_3333, 32'hE444_4444, 32'hE555_5555};
        txn(4'h7, BASE + 32'h18, 0, 6, 0, c);
        wq.delete();
        txn(4'h6, BASE + 32'h18, 0, 4, 0, c);
        chk(rq.size() == 4, "R10 read of stopped burst", rq.size(), 4);
        if (rq.size() == 4) begin
            chk(rq[0] == 32'hE000_0000, "R10 idx6", rq[0], 32'hE000_0000);
            chk(rq[1] == 32'hE111_1111, "R8 idx7", rq[1], 32'hE111_1111);
            chk(rq[2] == 32'hE222_2222, "R8 wrap idx0", rq[2], 32'hE222_2222);
            chk(rq[3] == 32'hE333_3333, "R10 idx1", rq[3], 32'hE333_3333);
        end
        txn(4'h6, BASE + 32'h8, 0, 1, 0, c);
        chk(rq.size() == 1 && rq[0] == eb, "R10 word past stop not written",
            rq.size() > 0 ? rq[0] : 32'hFFFF_FFFF, eb);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule